// File: doc/BRIEF.md
# Event-Selected Chainable Performance Counter Bank

This block is a small bank of event counters for a processor core. A wide event bus arrives every cycle, and each bit or group of bits on it reports how many times one kind of activity happened in that cycle. Each counter holds an 8-bit event number. That number picks one slice of the bus, and the slice is read as an unsigned count and added to the counter on every enabled cycle. Some slices are several bits wide, so one event can add more than one per cycle.

An odd counter can be linked to the even counter just below it, so that the pair works as one 64-bit count. A counter that wraps past its top bit raises a sticky overflow flag. Flags that are enabled for interrupts are ORed onto one interrupt line. A free-running 64-bit cycle counter sits next to the bank. Software reaches all the state through a simple register port: writes happen on the clock edge and reads are combinational.

Top module: `pmc_bank`

## Requirements
- R1: After reset, all counter values, event numbers (0x00), enable bits, interrupt-enable bits, overflow flags and the cycle counter are zero, and irq is low.
- R2: An event counter adds the unsigned value of the bus slice picked by its event number. Event numbers and slices: 0x00 bit 0, 0x01 bit 1, 0x02 bit 2, 0x04 bits [5:3], 0x05 bits [7:6], 0x08 bits [12:8], 0x09 bit 13, 0x0A bit 14, 0x10 bit 15, 0x12 bits [17:16], 0x13 bits [20:18], 0x1B bits [38:35], 0x25 bits [49:47] (a load and a store in the same cycle give 2), 0x70 bits [107:104], 0x71 bits [111:108]. Bits outside the slice have no effect.
- R3: Event 0x60 counts read beats on bit 91, and event 0x61 counts write beats on bit 92. Event 0x19 adds bit 91 plus bit 92, so it adds 2 in a cycle that has both beats.
- R4: Event 0x11 and event 0x1D both count bus bit 177, and they count identically.
- R5: A counter whose event number is not in R2, R3, R4 or R11 (for example 0x06 or 0xFF) never increments, even when every bus bit is 1.
- R6: The register at address 0 holds the enables. Bit i enables event counter i, and bit NUM_CNT enables the cycle counter. A disabled counter holds its value.
- R7: Counter i's value is at address 8+2i. A write there loads the written value and replaces that cycle's increment.
- R8: Counter i's event number is at address 9+2i (low 8 bits). A new number takes effect from the cycle after the write, and the write leaves the counter value unchanged.
- R9: A carry out of a counter's top bit sets its sticky flag in the register at address 2 (bit i for counter i, bit NUM_CNT for the cycle counter). Writing 1 to a bit clears that flag.
- R10: irq is high exactly when some flag is set and its bit in the interrupt-enable register at address 1 is also set.
- R11: An odd counter that selects event 0x1E adds exactly 1 in the same cycle that counter i-1 carries out, so the pair counts as one 64-bit value.
- R12: An even counter that selects event 0x1E never increments.
- R13: When enabled, the cycle counter adds 1 every clock. It reads at address 3 (low word) and address 4 (high word), and software cannot write it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_bus | input | 185 | Per-cycle event occurrence bus |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Overflow interrupt |

## Verification
An event present on the bus during one rising edge shows up in the counter value on reg_rdata right after that edge. An overflow flag is set on the same edge as the wrap, and irq follows the flags and enables with no further register. A changed event number or enable bit is captured on the write edge and first steers an increment on the following edge, so the cycle counter reads N after N edges that follow the enabling write. The bench drives the bus and the register port on falling edges and reads half a period later, so every read sees exactly the rising edges it has counted.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int EVT_BUS_W   = 185;
  localparam int EVT_NUM_W   = 8;
  localparam int FIELD_MAX_W = 5;

  localparam int A_ENABLE   = 0;
  localparam int A_IRQ_EN   = 1;
  localparam int A_OVF      = 2;
  localparam int A_CYC_LO   = 3;
  localparam int A_CYC_HI   = 4;
  localparam int A_CNT_BASE = 8;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_SLICE,
    SRC_PAIR,
    SRC_CHAIN
  } src_kind_e;

  typedef struct packed {
    src_kind_e  kind;
    logic [7:0] lo;
    logic [2:0] width;
  } evt_map_t;

  function automatic evt_map_t mk_map(input src_kind_e k, input int lo, input int w);
    evt_map_t m;
    m.kind  = k;
    m.lo    = 8'(lo);
    m.width = 3'(w);
    return m;
  endfunction

  // Event number to bus slice; numbers not listed are reserved
  function automatic evt_map_t evt_lookup(input logic [EVT_NUM_W-1:0] num);
    evt_map_t m;
    case (num)
      8'h00: m = mk_map(SRC_SLICE, 0, 1);
      8'h01: m = mk_map(SRC_SLICE, 1, 1);
      8'h02: m = mk_map(SRC_SLICE, 2, 1);
      8'h04: m = mk_map(SRC_SLICE, 3, 3);
      8'h05: m = mk_map(SRC_SLICE, 6, 2);
      8'h08: m = mk_map(SRC_SLICE, 8, 5);
      8'h09: m = mk_map(SRC_SLICE, 13, 1);
      8'h0A: m = mk_map(SRC_SLICE, 14, 1);
      8'h10: m = mk_map(SRC_SLICE, 15, 1);
      8'h11: m = mk_map(SRC_SLICE, 177, 1);
      8'h12: m = mk_map(SRC_SLICE, 16, 2);
      8'h13: m = mk_map(SRC_SLICE, 18, 3);
      8'h19: m = mk_map(SRC_PAIR, 91, 2);
      8'h1B: m = mk_map(SRC_SLICE, 35, 4);
      8'h1D: m = mk_map(SRC_SLICE, 177, 1);
      8'h1E: m = mk_map(SRC_CHAIN, 0, 0);
      8'h25: m = mk_map(SRC_SLICE, 47, 3);
      8'h60: m = mk_map(SRC_SLICE, 91, 1);
      8'h61: m = mk_map(SRC_SLICE, 92, 1);
      8'h70: m = mk_map(SRC_SLICE, 104, 4);
      8'h71: m = mk_map(SRC_SLICE, 108, 4);
      default: m = mk_map(SRC_NONE, 0, 0);
    endcase
    return m;
  endfunction

  // Occurrence count carried by the mapped slice in this cycle
  function automatic logic [FIELD_MAX_W-1:0] field_value(input logic [EVT_BUS_W-1:0] bus,
                                                         input evt_map_t m);
    logic [FIELD_MAX_W-1:0] v;
    int idx;
    v = '0;
    case (m.kind)
      SRC_SLICE: begin
        for (int k = 0; k < FIELD_MAX_W; k++) begin
          idx = int'(m.lo) + k;
          if (k < int'(m.width) && idx < EVT_BUS_W) v[k] = bus[idx];
        end
      end
      SRC_PAIR: begin
        idx = int'(m.lo);
        if (idx + 1 < EVT_BUS_W)
          v = FIELD_MAX_W'(bus[idx]) + FIELD_MAX_W'(bus[idx+1]);
      end
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pmc_event_sel.sv
module pmc_event_sel
  import pmc_pkg::*;
(
  input  logic [EVT_BUS_W-1:0]   bus,
  input  logic [EVT_NUM_W-1:0]   evt_num,
  output logic [FIELD_MAX_W-1:0] inc,
  output logic                   chain_sel,
  output logic                   rsvd_sel
);

  evt_map_t map;

  always_comb begin
    map       = evt_lookup(evt_num);
    inc       = field_value(bus, map);
    chain_sel = (map.kind == SRC_CHAIN);
    rsvd_sel  = (map.kind == SRC_NONE);
  end

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W     = 32,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  input  logic             chain_in,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     value,
  output logic             carry
);

  localparam int SW = W + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum   = {1'b0, value} + SW'(inc) + SW'(chain_in);
    carry = en && !wr && sum[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (wr)  value <= wdata;
    else if (en)  value <= sum[W-1:0];
  end

  // R7
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> value == $past(wdata));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr) |=> $stable(value));

endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] flags,
  output logic         irq
);

  logic [N-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_wr ? clr_mask : '0;
    irq     = |(flags & irq_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set;
  end

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_BUS_W-1:0] evt_bus,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic                 irq
);

  localparam int NFLAG = NUM_CNT + 1;
  localparam int CYC_W = 2 * CNT_W;

  logic [NFLAG-1:0]       en_q;
  logic [NFLAG-1:0]       irqen_q;
  logic [NFLAG-1:0]       ovf_flags;
  logic [NFLAG-1:0]       ovf_set;
  logic [EVT_NUM_W-1:0]   evt_q   [NUM_CNT];
  logic [FIELD_MAX_W-1:0] inc     [NUM_CNT];
  logic [CNT_W-1:0]       cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0]     chain_sel, rsvd_sel, chain_in, cnt_carry, cnt_wr, evt_wr;
  logic [CYC_W-1:0]       cyc_val;
  logic                   cyc_carry;
  logic                   en_wr, irqen_wr, ovf_wr;

  assign en_wr    = reg_wr && (reg_addr == ADDR_W'(A_ENABLE));
  assign irqen_wr = reg_wr && (reg_addr == ADDR_W'(A_IRQ_EN));
  assign ovf_wr   = reg_wr && (reg_addr == ADDR_W'(A_OVF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      irqen_q <= '0;
    end else begin
      if (en_wr)    en_q    <= reg_wdata[NFLAG-1:0];
      if (irqen_wr) irqen_q <= reg_wdata[NFLAG-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_wr[i] = reg_wr && (reg_addr == ADDR_W'(A_CNT_BASE + 2*i));
    assign evt_wr[i] = reg_wr && (reg_addr == ADDR_W'(A_CNT_BASE + 2*i + 1));

    always_ff @(posedge clk) begin
      if (!rst_n)         evt_q[i] <= '0;
      else if (evt_wr[i]) evt_q[i] <= reg_wdata[EVT_NUM_W-1:0];
    end

    pmc_event_sel u_sel (
      .bus       (evt_bus),
      .evt_num   (evt_q[i]),
      .inc       (inc[i]),
      .chain_sel (chain_sel[i]),
      .rsvd_sel  (rsvd_sel[i])
    );

    if (i % 2 == 1) begin : g_odd
      assign chain_in[i] = chain_sel[i] & cnt_carry[i-1];

      // R11
      chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel[i] && cnt_carry[i-1] && en_q[i] && !cnt_wr[i])
          |=> cnt_val[i] == $past(cnt_val[i]) + CNT_W'(1));
    end else begin : g_even
      assign chain_in[i] = 1'b0;

      // R12
      even_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel[i] && !cnt_wr[i]) |=> $stable(cnt_val[i]));
    end

    pmc_counter #(
      .W     (CNT_W),
      .INC_W (FIELD_MAX_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q[i]),
      .inc      (inc[i]),
      .chain_in (chain_in[i]),
      .wr       (cnt_wr[i]),
      .wdata    (reg_wdata),
      .value    (cnt_val[i]),
      .carry    (cnt_carry[i])
    );

    // R5
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsvd_sel[i] && !cnt_wr[i]) |=> $stable(cnt_val[i]));
  end

  pmc_counter #(
    .W     (CYC_W),
    .INC_W (1)
  ) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q[NUM_CNT]),
    .inc      (1'b1),
    .chain_in (1'b0),
    .wr       (1'b0),
    .wdata    ({CYC_W{1'b0}}),
    .value    (cyc_val),
    .carry    (cyc_carry)
  );

  assign ovf_set = {cyc_carry, cnt_carry};

  pmc_status #(
    .N (NFLAG)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (ovf_set),
    .clr_wr   (ovf_wr),
    .clr_mask (reg_wdata[NFLAG-1:0]),
    .irq_en   (irqen_q),
    .flags    (ovf_flags),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_ENABLE)) reg_rdata = CNT_W'(en_q);
    if (reg_addr == ADDR_W'(A_IRQ_EN)) reg_rdata = CNT_W'(irqen_q);
    if (reg_addr == ADDR_W'(A_OVF))    reg_rdata = CNT_W'(ovf_flags);
    if (reg_addr == ADDR_W'(A_CYC_LO)) reg_rdata = cyc_val[CNT_W-1:0];
    if (reg_addr == ADDR_W'(A_CYC_HI)) reg_rdata = cyc_val[CYC_W-1:CNT_W];
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(A_CNT_BASE + 2*i))     reg_rdata = cnt_val[i];
      if (reg_addr == ADDR_W'(A_CNT_BASE + 2*i + 1)) reg_rdata = CNT_W'(evt_q[i]);
    end
  end

endmodule

// File: tb/pmc_bank_test.sv
module pmc_bank_test;

  localparam int BW = 185;
  localparam logic [5:0] AD_EN   = 6'd0;
  localparam logic [5:0] AD_IRQ  = 6'd1;
  localparam logic [5:0] AD_OVF  = 6'd2;
  localparam logic [5:0] AD_CYL  = 6'd3;
  localparam logic [5:0] AD_CYH  = 6'd4;

  // {event, slice low bit, pattern, expected increment}
  localparam int NV = 20;
  localparam logic [31:0] VEC [NV] = '{
    32'h00_00_01_01, 32'h04_03_07_07, 32'h04_03_05_05, 32'h08_08_1F_1F,
    32'h08_08_15_15, 32'h1B_23_0F_0F, 32'h09_0D_01_01, 32'h09_0C_01_00,
    32'h25_2F_02_02, 32'h25_2F_07_07, 32'h19_5B_03_02, 32'h19_5B_01_01,
    32'h60_5B_03_01, 32'h61_5B_03_01, 32'h1D_B1_01_01, 32'h11_B1_01_01,
    32'h05_06_03_03, 32'h13_12_07_07, 32'h70_68_09_09, 32'h71_6C_0F_0F
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] bus = '0;
  logic          reg_wr = 1'b0;
  logic [5:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  pmc_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_bus   (bus),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  function automatic logic [5:0] a_cnt(input int i);
    return 6'(8 + 2*i);
  endfunction

  function automatic logic [5:0] a_evt(input int i);
    return 6'(9 + 2*i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 cnt0", a_cnt(0), 0);
    rd_chk("R1 cnt3", a_cnt(3), 0);
    rd_chk("R1 evt2", a_evt(2), 0);
    rd_chk("R1 enable", AD_EN, 0);
    rd_chk("R1 ovf", AD_OVF, 0);
    rd_chk("R1 cyc", AD_CYL, 0);
    check("R1 irq", 32'(irq), 0);

    // R6 disabled counter holds
    bus[0] = 1'b1;
    repeat (3) @(negedge clk);
    bus = '0;
    rd_chk("R6 disabled", a_cnt(0), 0);

    wr(AD_EN, 32'h0F);

    // R2 R3 R4 vector table on counter 0
    for (int v = 0; v < NV; v++) begin
      logic [7:0] ev, ps, pt, ex;
      string tag;
      {ev, ps, pt, ex} = VEC[v];
      tag = (ev == 8'h19 || ev == 8'h60 || ev == 8'h61) ? "R3 vec" :
            (ev == 8'h11 || ev == 8'h1D) ? "R4 vec" : "R2 vec";
      wr(a_cnt(0), 0);
      wr(a_evt(0), 32'(ev));
      bus = BW'(pt) << ps;
      @(negedge clk);
      bus = '0;
      rd_chk(tag, a_cnt(0), 32'(ex));
    end

    // R7 write beats the increment
    wr(a_evt(0), 32'h00);
    bus[0] = 1'b1;
    wr(a_cnt(0), 100);
    bus = '0;
    rd_chk("R7 write priority", a_cnt(0), 100);

    // R8 event change applies next cycle, value kept
    wr(a_cnt(0), 0);
    bus[0] = 1'b1;
    bus[5:3] = 3'd3;
    wr(a_evt(0), 32'h04);
    rd_chk("R8 old event in write cycle", a_cnt(0), 1);
    @(negedge clk);
    bus = '0;
    rd_chk("R8 new event next cycle", a_cnt(0), 4);
    rd_chk("R8 event readback", a_evt(0), 32'h04);

    // R9 R10 overflow flag and interrupt
    wr(a_cnt(0), 32'hFFFF_FFFE);
    bus[5:3] = 3'd3;
    @(negedge clk);
    bus = '0;
    rd_chk("R9 wrapped value", a_cnt(0), 1);
    rd_chk("R9 flag set", AD_OVF, 1);
    check("R10 irq masked", 32'(irq), 0);
    wr(AD_IRQ, 1);
    check("R10 irq enabled", 32'(irq), 1);
    wr(AD_OVF, 1);
    rd_chk("R9 flag cleared", AD_OVF, 0);
    check("R10 irq after clear", 32'(irq), 0);

    // R11 chain odd on even carry
    wr(a_evt(0), 32'h00);
    wr(a_cnt(0), 32'hFFFF_FFFF);
    wr(a_cnt(1), 5);
    wr(a_evt(1), 32'h1E);
    bus[0] = 1'b1;
    @(negedge clk);
    bus = '0;
    rd_chk("R11 low half", a_cnt(0), 0);
    rd_chk("R11 high half", a_cnt(1), 6);
    bus[0] = 1'b1;
    @(negedge clk);
    bus = '0;
    rd_chk("R11 no carry no step", a_cnt(1), 6);
    rd_chk("R11 low flag only", AD_OVF, 1);
    wr(AD_OVF, 3);
    wr(a_cnt(0), 32'hFFFF_FFFF);
    wr(a_cnt(1), 32'hFFFF_FFFF);
    bus[0] = 1'b1;
    @(negedge clk);
    bus = '0;
    rd_chk("R11 64-bit wrap high", a_cnt(1), 0);
    rd_chk("R11 both flags", AD_OVF, 3);

    // R12 chain on even counter
    wr(a_cnt(2), 9);
    wr(a_evt(2), 32'h1E);
    bus = '1;
    repeat (3) @(negedge clk);
    bus = '0;
    rd_chk("R12 even chain", a_cnt(2), 9);

    // R5 reserved events
    wr(a_cnt(3), 7);
    wr(a_evt(3), 32'h06);
    bus = '1;
    repeat (3) @(negedge clk);
    bus = '0;
    rd_chk("R5 reserved 0x06", a_cnt(3), 7);
    wr(a_evt(3), 32'hFF);
    bus = '1;
    repeat (3) @(negedge clk);
    bus = '0;
    rd_chk("R5 reserved 0xFF", a_cnt(3), 7);

    // R13 cycle counter
    rd_chk("R13 idle", AD_CYL, 0);
    wr(AD_EN, 32'h1F);
    repeat (10) @(negedge clk);
    rd_chk("R13 ten cycles", AD_CYL, 10);
    rd_chk("R13 high word", AD_CYH, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule